// File: doc/BRIEF.md
# Word-Parallel EPROM Burn-and-Verify Sequencer

This block programs a blank word-organized EPROM from an image held in a local read-only port. It starts at address zero and works upward through the whole array. For each word it drives the 16-bit target value and a fixed-width program strobe, then reads the same location back. It fires another strobe only while the readback still differs from the target. A word that never matches within the pulse budget ends the job as a failure.

Once the last address has been burned, the block makes a second pass over every location. This pass only reads, and it runs with the supply selects switched to the margin setting. The margin setting means both rails at the nominal-high verify level, with the programming voltage released.

The sequencer drives the memory-side strobes and three supply-select flags, and the analog rails follow those flags. A host starts a job with `start`. It watches `busy` during the job and reads `done`, `fail` and `fail_addr` when the job ends.

Top module: `eprom_prog_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `done` and `fail` are 0. `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are 1, and `mem_wdata_oe` and all three supply selects are 0.
- R2: Each program strobe holds `mem_pgm_n` low for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 clock cycles. Throughout the strobe, `mem_ce_n` is low, `mem_oe_n` is high, `mem_wdata_oe` is high, `mem_wdata` carries the image word, and `vpp_prog_en` and `vcc_prog_en` are high.
- R3: When a strobe ends, the next cycle is a verify read with `mem_ce_n` and `mem_oe_n` low and `vpp_prog_en` still high. `mem_rdata` is sampled SETTLE_CYC cycles after the read begins. A further strobe is issued only if the sampled word differs from the target.
- R4: Addresses are burned in ascending order, from 0 to 2^AW-1, and each location ends holding its image word.
- R5: A location whose image word is all ones (16'hFFFF) receives no strobe.
- R6: If a location still mismatches after MAX_PULSES strobes, the job stops at once. `fail` and `done` go to 1, `fail_addr` holds that address, and no later address gets a strobe.
- R7: After the last address, every location is read once more with `vcc_vfy_en` high and both `vpp_prog_en` and `vcc_prog_en` low. Any mismatch in this pass sets `fail` and `done` and records the address in `fail_addr`.
- R8: A clean job ends with `done`=1, `fail`=0 and `busy`=0. `done` holds until the next `start`, and a `start` seen while `busy` is high has no effect.
- R9: The write data driver (`mem_wdata_oe`) is active only while the program strobe is low and `mem_oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (sampled while idle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished; held until next start |
| fail | output | 1 | Job ended in error |
| fail_addr | output | AW | Address of the failing location |
| img_addr | output | AW | Image port address |
| img_data | input | DW | Image word, valid one cycle after img_addr |
| mem_addr | output | AW | Memory address pins |
| mem_wdata | output | DW | Word driven onto the data pins |
| mem_wdata_oe | output | 1 | Enables the data pin driver |
| mem_rdata | input | DW | Word read back from the data pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_prog_en | output | 1 | Selects the high programming voltage |
| vcc_prog_en | output | 1 | Selects the raised supply for burning |
| vcc_vfy_en | output | 1 | Selects the margin-verify supply level |

## Verification
A corrupted strobe timer appears in the very next pulse as a wrong strobe width. A corrupted retry count appears within one address as a pulse count that differs from the number the cell model needs. A wrong address counter appears at the first pulse that lands on an unexpected location, or as a skipped location in the margin pass. A bad final comparison cannot be seen until the job ends. There it shows as a wrong `fail`/`fail_addr` pair or as memory contents that differ from the image.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_PULSE,
    S_SETTLE,
    S_NEXT,
    S_VFETCH,
    S_VLOAD,
    S_VSETTLE
  } seq_state_e;

  function automatic logic in_burn_pass(input seq_state_e s);
    return (s == S_FETCH) || (s == S_LOAD) || (s == S_PULSE) ||
           (s == S_SETTLE) || (s == S_NEXT);
  endfunction

  function automatic logic in_margin_pass(input seq_state_e s);
    return (s == S_VFETCH) || (s == S_VLOAD) || (s == S_VSETTLE);
  endfunction
endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_prog_fsm.sv
module eprom_prog_fsm
  import eprom_prog_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int MAX_PULSES = 25,
  parameter int PULSE_CYC  = 5000,
  parameter int SETTLE_CYC = 4,
  parameter int TW         = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] img_data,
  input  logic [DW-1:0] mem_rdata,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          wdata_oe,
  output logic          ce_n,
  output logic          oe_n,
  output logic          pgm_n,
  output logic          vpp_prog,
  output logic          vcc_prog,
  output logic          vcc_vfy
);
  localparam int            PCW       = $clog2(MAX_PULSES + 1);
  localparam logic [AW-1:0] LAST_ADDR = '1;
  localparam logic [DW-1:0] BLANK     = '1;
  localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);

  seq_state_e     st_q, st_d;
  logic [DW-1:0]  word_q;
  logic [PCW-1:0] pcnt_q;
  logic           match, end_ok, end_bad;

  assign match = (mem_rdata == word_q);
  assign wdata = word_q;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    end_ok   = 1'b0;
    end_bad  = 1'b0;
    case (st_q)
      S_IDLE:   if (start) st_d = S_FETCH;
      S_FETCH:  st_d = S_LOAD;
      S_LOAD:
        if (img_data == BLANK) st_d = S_NEXT;
        else begin
          st_d = S_PULSE; tmr_load = 1'b1; tmr_val = PULSE_LD;
        end
      S_PULSE:
        if (tmr_expired) begin
          st_d = S_SETTLE; tmr_load = 1'b1; tmr_val = SETTLE_LD;
        end
      S_SETTLE:
        if (tmr_expired) begin
          if (match) st_d = S_NEXT;
          else if (pcnt_q >= PCW'(MAX_PULSES)) begin
            st_d = S_IDLE; end_bad = 1'b1;
          end else begin
            st_d = S_PULSE; tmr_load = 1'b1; tmr_val = PULSE_LD;
          end
        end
      S_NEXT:   st_d = (addr == LAST_ADDR) ? S_VFETCH : S_FETCH;
      S_VFETCH: st_d = S_VLOAD;
      S_VLOAD: begin
        st_d = S_VSETTLE; tmr_load = 1'b1; tmr_val = SETTLE_LD;
      end
      S_VSETTLE:
        if (tmr_expired) begin
          if (!match) begin
            st_d = S_IDLE; end_bad = 1'b1;
          end else if (addr == LAST_ADDR) begin
            st_d = S_IDLE; end_ok = 1'b1;
          end else st_d = S_VFETCH;
        end
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      addr      <= '0;
      word_q    <= '0;
      pcnt_q    <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      busy      <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      pgm_n     <= 1'b1;
      wdata_oe  <= 1'b0;
      vpp_prog  <= 1'b0;
      vcc_prog  <= 1'b0;
      vcc_vfy   <= 1'b0;
    end else begin
      st_q <= st_d;
      case (st_q)
        S_IDLE:
          if (start) begin
            addr <= '0; done <= 1'b0; fail <= 1'b0; fail_addr <= '0;
          end
        S_LOAD: begin
          word_q <= img_data;
          pcnt_q <= (img_data == BLANK) ? '0 : PCW'(1);
        end
        S_SETTLE:  if (st_d == S_PULSE) pcnt_q <= pcnt_q + 1'b1;
        S_NEXT:    addr <= addr + 1'b1;  // wraps to 0 for the margin pass
        S_VLOAD:   word_q <= img_data;
        S_VSETTLE: if (st_d == S_VFETCH) addr <= addr + 1'b1;
        default: ;
      endcase
      if (end_ok) done <= 1'b1;
      if (end_bad) begin
        done <= 1'b1; fail <= 1'b1; fail_addr <= addr;
      end
      busy     <= (st_d != S_IDLE);
      ce_n     <= !((st_d == S_PULSE) || (st_d == S_SETTLE) || (st_d == S_VSETTLE));
      oe_n     <= !((st_d == S_SETTLE) || (st_d == S_VSETTLE));
      pgm_n    <= (st_d != S_PULSE);
      wdata_oe <= (st_d == S_PULSE);
      vpp_prog <= in_burn_pass(st_d);
      vcc_prog <= in_burn_pass(st_d);
      vcc_vfy  <= in_margin_pass(st_d);
    end
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [AW-1:0] img_addr,
  input  logic [DW-1:0] img_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic          vpp_prog_en,
  output logic          vcc_prog_en,
  output logic          vcc_vfy_en
);
  localparam int PULSE_RAW = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int SET_CYC   = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
  localparam int LONGEST   = (PULSE_CYC > SET_CYC) ? PULSE_CYC : SET_CYC;
  localparam int TW        = $clog2(LONGEST + 1);

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic [AW-1:0] addr;

  assign img_addr = addr;
  assign mem_addr = addr;

  eprom_prog_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  eprom_prog_fsm #(
    .AW(AW), .DW(DW), .MAX_PULSES(MAX_PULSES),
    .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SET_CYC), .TW(TW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .img_data    (img_data),
    .mem_rdata   (mem_rdata),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .fail_addr   (fail_addr),
    .addr        (addr),
    .wdata       (mem_wdata),
    .wdata_oe    (mem_wdata_oe),
    .ce_n        (mem_ce_n),
    .oe_n        (mem_oe_n),
    .pgm_n       (mem_pgm_n),
    .vpp_prog    (vpp_prog_en),
    .vcc_prog    (vcc_prog_en),
    .vcc_vfy     (vcc_vfy_en)
  );
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic fail,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_pgm_n,
  input logic mem_wdata_oe,
  input logic vpp_prog_en,
  input logic vcc_prog_en,
  input logic vcc_vfy_en
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fail && mem_pgm_n && mem_ce_n && mem_oe_n && !vpp_prog_en));

  assert_pulse_env_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && vpp_prog_en && vcc_prog_en));

  assert_verify_follows_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_pgm_n) |-> (!mem_oe_n && !mem_ce_n && vpp_prog_en));

  assert_fail_ends_R6: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  assert_margin_supply_R7: assert property (@(posedge clk) disable iff (rst)
    vcc_vfy_en |-> (!vpp_prog_en && !vcc_prog_en));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_driver_gate_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wdata_oe |-> (!mem_pgm_n && mem_oe_n));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .fail         (fail),
  .mem_ce_n     (mem_ce_n),
  .mem_oe_n     (mem_oe_n),
  .mem_pgm_n    (mem_pgm_n),
  .mem_wdata_oe (mem_wdata_oe),
  .vpp_prog_en  (vpp_prog_en),
  .vcc_prog_en  (vcc_prog_en),
  .vcc_vfy_en   (vcc_vfy_en)
);

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;
  localparam int AW     = 4;
  localparam int DW     = 16;
  localparam int N      = 1 << AW;
  localparam int CLK_HZ = 200_000;
  localparam int PUS    = 100;
  localparam int MAXP   = 5;
  localparam int SETC   = 3;
  localparam int PCYC   = (CLK_HZ / 1000) * PUS / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, fail;
  logic [AW-1:0] fail_addr, img_addr, mem_addr;
  logic [DW-1:0] img_data, mem_wdata, mem_rdata;
  logic mem_wdata_oe, mem_ce_n, mem_oe_n, mem_pgm_n;
  logic vpp_prog_en, vcc_prog_en, vcc_vfy_en;

  always #10 clk = ~clk;

  eprom_prog_seq #(
    .AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .PULSE_US(PUS),
    .MAX_PULSES(MAXP), .SETTLE_CYC(SETC)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .img_addr(img_addr),
    .img_data(img_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
    .vpp_prog_en(vpp_prog_en), .vcc_prog_en(vcc_prog_en),
    .vcc_vfy_en(vcc_vfy_en)
  );

  logic [DW-1:0] image [N];
  logic [DW-1:0] cells [N];
  int            need  [N];
  int            got   [N];
  logic [N-1:0]  vfy_mask;
  bit            weak_en = 1'b0;
  logic [AW-1:0] weak_addr = '0;
  int            expq [$];
  int            nchk = 0;
  int            nerr = 0;
  int            width = 0;
  int            total_cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // image port, one cycle of latency
  always @(posedge clk) img_data <= image[img_addr];

  // cell model: reads, with an optional weak word under margin supply
  always_comb begin
    if (!mem_ce_n && !mem_oe_n)
      mem_rdata = cells[mem_addr] ^
                  ((vcc_vfy_en && weak_en && mem_addr == weak_addr) ? 16'h0001 : 16'h0000);
    else
      mem_rdata = 16'hDEAD;
  end

  // monitor: pops one expected address per strobe and updates the cells
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_pgm_n) width++;
      else if (width != 0) begin
        if (expq.size() == 0)
          check(1'b0, "R5", "unexpected strobe at address", 32'(mem_addr), 32'hFFFF_FFFF);
        else begin
          int e;
          e = expq.pop_front();
          check(32'(mem_addr) == e, "R4", "strobe address", 32'(mem_addr), e);
          check(width == PCYC, "R2", "strobe width", width, PCYC);
        end
        got[mem_addr] = got[mem_addr] + 1;
        if (got[mem_addr] >= need[mem_addr])
          cells[mem_addr] = cells[mem_addr] & mem_wdata;
        width = 0;
      end
      if (vcc_vfy_en && !mem_oe_n && !mem_ce_n) vfy_mask[mem_addr] = 1'b1;
    end
  end

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      nerr++;
      $display("FAIL R8 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  // driver: plans the expected strobe sequence, then runs one job
  task automatic run_case(input string tag, input bit exp_fail,
                          input int exp_addr, input bit poke);
    int cyc;
    expq.delete();
    for (int a = 0; a < N; a++) begin
      int n;
      if (image[a] == 16'hFFFF) continue;
      n = (need[a] > MAXP) ? MAXP : need[a];
      for (int k = 0; k < n; k++) expq.push_back(a);
      if (need[a] > MAXP) break;
    end
    for (int a = 0; a < N; a++) begin
      cells[a] = 16'hFFFF;
      got[a] = 0;
    end
    vfy_mask = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R8", {tag, " busy after start"}, {busy, done}, 2'b10);
    cyc = 0;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 100);  // R8: start while busy must be ignored
    end
    start = 1'b0;
    if (!done) begin
      check(1'b0, "R8", {tag, " job never finished"}, 0, 1);
      return;
    end
    check(expq.size() == 0, "R6", {tag, " strobes still expected"}, expq.size(), 0);
    check(fail == exp_fail, "R7", {tag, " fail flag"}, fail, exp_fail);
    check(busy == 1'b0, "R8", {tag, " busy at end"}, busy, 0);
    if (exp_fail)
      check(32'(fail_addr) == exp_addr, "R6", {tag, " fail_addr"}, fail_addr, exp_addr);
    else begin
      bit same = 1'b1;
      for (int a = 0; a < N; a++) if (cells[a] != image[a]) same = 1'b0;
      check(same, "R4", {tag, " contents equal image"}, same, 1);
      check(vfy_mask == '1, "R7", {tag, " margin pass coverage"}, vfy_mask, {N{1'b1}});
    end
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8", {tag, " done held"}, done, 1);
  endtask

  initial begin
    for (int a = 0; a < N; a++) begin
      image[a] = (a % 5 == 2) ? 16'hFFFF : (16'hA5C3 ^ DW'(a * 16'h1111));
      need[a]  = 1 + (a % 3);
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail, "R1", "status after reset", {busy, done, fail}, 0);
    check(mem_ce_n && mem_oe_n && mem_pgm_n, "R1", "strobes after reset",
          {mem_ce_n, mem_oe_n, mem_pgm_n}, 3'b111);
    check(!mem_wdata_oe && !vpp_prog_en && !vcc_prog_en && !vcc_vfy_en, "R1",
          "drivers after reset", {mem_wdata_oe, vpp_prog_en, vcc_prog_en, vcc_vfy_en}, 0);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && mem_pgm_n && !vpp_prog_en, "R1", "idle after release",
          {busy, mem_pgm_n, vpp_prog_en}, 3'b010);

    // clean job with varying pulse needs, blanks skipped (R3, R5), start poked mid-run
    run_case("clean", 1'b0, 0, 1'b1);

    // a location needing more strobes than allowed
    need[5] = 7;
    run_case("limit", 1'b1, 5, 1'b0);
    need[5] = 1 + (5 % 3);

    // burn passes but one word is weak under the margin supply
    weak_en = 1'b1;
    weak_addr = 4'd9;
    run_case("margin", 1'b1, 9, 1'b0);
    weak_en = 1'b0;

    // blank image: no strobes at all (R5)
    for (int a = 0; a < N; a++) image[a] = 16'hFFFF;
    run_case("blank", 1'b0, 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule